// File: doc/BRIEF.md
# Cache-Line Request Splitter with Two-Phase Writes

This block accepts inbound DMA requests of any byte address and length and cuts them into commands that never cross a 64-byte line. Each command goes to one of several home agents, selected by a hash of the line address. A read request becomes one read-current command per line. The command always asks for the whole line, even when the device wanted only a few bytes of it.

A write request becomes a two-step exchange per line. First an ownership command goes out, tagged from a small pool of outstanding-write slots. Its opcode tells a fully covered line apart from a partially covered one, and a 64-bit byte-enable mask comes with it. When the agent returns a grant carrying that tag, the block sends the data message for the line to the same agent, with the same line address and mask. Grants may come back in any order. A write marked non-allocating ends with a flush command instead of the normal writeback.

The request side uses a valid/ready handshake. The command side is registered and one-hot by agent. At most one command leaves per cycle, and a pending writeback takes that slot ahead of a new piece.

Top module: `line_splitter`

## Requirements
- R1: While reset is held and in the first cycle after its release, `cmd_valid` is all zero and `req_ready` is high.
- R2: A request with start address A and length L+1 bytes (`req_len_m1` = L) issues one piece command per line from line A>>6 to line (A+L)>>6, in ascending line order, with the line number on `cmd_line`.
- R3: A write piece's `cmd_be` has bit i set exactly when byte i of that line lies inside the request. Bit 0 is the lowest byte address of the line.
- R4: Opcodes on `cmd_op`: 1 read-current, 2 full-line ownership, 3 partial-line ownership, 4 writeback data, 5 flush. Ownership uses 2 when all 64 mask bits are set and 3 otherwise.
- R5: A read piece uses opcode 1, an all-ones `cmd_be` and `cmd_tag` = 0, whatever part of the line was requested.
- R6: `cmd_valid` is one-hot0. When it is nonzero, the set bit is the XOR of all line-address bits b, each folded onto agent bit (b mod log2(N_AGENTS)).
- R7: Each ownership command is followed, only after a grant with its tag has arrived, by exactly one data command with the same tag, line, mask and agent.
- R8: A write with `req_noalloc` set ends each line with opcode 5 instead of opcode 4.
- R9: An ownership command takes the lowest-numbered free tag. Splitting a write stalls while no tag is free. A grant naming a tag that is not waiting for one has no effect.
- R10: When grants are pending, a data command is sent before any new piece, lowest granted tag first. A grant takes effect on the cycle after it is presented.
- R11: `req_ready` drops on the cycle after a request is accepted and rises again on the cycle after the last piece of that request is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_noalloc | input | 1 | Write ends in flush instead of writeback |
| req_addr | input | ADDR_W | Start byte address |
| req_len_m1 | input | LEN_W | Length in bytes minus one |
| cmd_valid | output | N_AGENTS | One-hot destination agent of the command |
| cmd_op | output | 3 | Command opcode |
| cmd_line | output | ADDR_W-6 | Line address |
| cmd_be | output | 64 | Byte-enable mask |
| cmd_tag | output | log2(N_TAGS) | Outstanding-write tag |
| gnt_valid | input | 1 | Ownership grant present |
| gnt_tag | input | log2(N_TAGS) | Tag being granted |

## Verification
The hardest state to reach is a long write that has used every tag while grants come back in reverse order. In that state the splitter stalls, and writebacks from released tags take turns with new ownership commands on the one command slot. The stimulus gets there with a 16-line write and a grant driver that holds grants until the pool is full and then releases the youngest first. A second driver mode sends grants for tags that are not waiting, and the behavioural model confirms that no early data command appears.

// File: rtl/ls_pkg.sv
package ls_pkg;
  localparam int LINE_BYTES = 64;
  localparam int OFF_W      = 6;

  typedef enum logic [2:0] {
    OP_IDLE     = 3'd0,
    OP_RD_CUR   = 3'd1,
    OP_OWN_FULL = 3'd2,
    OP_OWN_PART = 3'd3,
    OP_WB_DATA  = 3'd4,
    OP_WB_FLUSH = 3'd5
  } cmd_op_e;
endpackage

// File: rtl/ls_line_hash.sv
module ls_line_hash #(
  parameter int LINE_W  = 34,
  parameter int AGENT_W = 3
) (
  input  logic [LINE_W-1:0]  line,
  output logic [AGENT_W-1:0] agent
);
  // fold every line bit onto agent bit (b mod AGENT_W)
  always_comb begin
    agent = '0;
    for (int b = 0; b < LINE_W; b++) begin
      agent[b % AGENT_W] = agent[b % AGENT_W] ^ line[b];
    end
  end
endmodule

// File: rtl/ls_piece_mask.sv
module ls_piece_mask import ls_pkg::*; (
  input  logic [OFF_W-1:0]      lo,
  input  logic [OFF_W-1:0]      hi,
  output logic [LINE_BYTES-1:0] be,
  output logic                  full
);
  localparam logic [OFF_W-1:0] TOP = OFF_W'(LINE_BYTES - 1);

  always_comb begin
    be   = ({LINE_BYTES{1'b1}} << lo) & ({LINE_BYTES{1'b1}} >> (TOP - hi));
    full = (lo == '0) && (hi == TOP);
  end
endmodule

// File: rtl/ls_tag_table.sv
module ls_tag_table import ls_pkg::*; #(
  parameter int N_TAGS  = 4,
  parameter int LINE_W  = 34,
  parameter int AGENT_W = 3,
  localparam int TAG_W  = $clog2(N_TAGS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  alloc_en,
  input  logic [LINE_W-1:0]     alloc_line,
  input  logic [LINE_BYTES-1:0] alloc_be,
  input  logic [AGENT_W-1:0]    alloc_agent,
  input  logic                  alloc_na,
  input  logic                  gnt_valid,
  input  logic [TAG_W-1:0]      gnt_tag,
  input  logic                  retire_en,
  output logic                  free_any,
  output logic [TAG_W-1:0]      free_idx,
  output logic                  rdy_any,
  output logic [TAG_W-1:0]      rdy_idx,
  output logic [LINE_W-1:0]     ent_line,
  output logic [LINE_BYTES-1:0] ent_be,
  output logic [AGENT_W-1:0]    ent_agent,
  output logic                  ent_na
);
  logic [N_TAGS-1:0]     busy_q, busy_d, grt_q, grt_d;
  logic [LINE_W-1:0]     line_q  [N_TAGS];
  logic [LINE_BYTES-1:0] be_q    [N_TAGS];
  logic [AGENT_W-1:0]    agent_q [N_TAGS];
  logic [N_TAGS-1:0]     na_q;

  always_comb begin
    free_any = 1'b0;
    free_idx = '0;
    rdy_any  = 1'b0;
    rdy_idx  = '0;
    for (int t = N_TAGS - 1; t >= 0; t--) begin
      if (!busy_q[t]) begin
        free_any = 1'b1;
        free_idx = TAG_W'(t);
      end
      if (grt_q[t]) begin
        rdy_any = 1'b1;
        rdy_idx = TAG_W'(t);
      end
    end
  end

  assign ent_line  = line_q[rdy_idx];
  assign ent_be    = be_q[rdy_idx];
  assign ent_agent = agent_q[rdy_idx];
  assign ent_na    = na_q[rdy_idx];

  always_comb begin
    busy_d = busy_q;
    grt_d  = grt_q;
    if (gnt_valid && busy_q[gnt_tag] && !grt_q[gnt_tag]) grt_d[gnt_tag] = 1'b1;
    if (retire_en) begin
      busy_d[rdy_idx] = 1'b0;
      grt_d[rdy_idx]  = 1'b0;
    end
    if (alloc_en) busy_d[free_idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= '0;
      grt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      grt_q  <= grt_d;
    end
  end

  generate
    for (genvar g = 0; g < N_TAGS; g++) begin : g_entry
      always_ff @(posedge clk) begin
        if (alloc_en && (free_idx == TAG_W'(g))) begin
          line_q[g]  <= alloc_line;
          be_q[g]    <= alloc_be;
          agent_q[g] <= alloc_agent;
          na_q[g]    <= alloc_na;
        end
      end
    end
  endgenerate
endmodule

// File: rtl/line_splitter.sv
module line_splitter import ls_pkg::*; #(
  parameter int ADDR_W   = 40,
  parameter int LEN_W    = 12,
  parameter int N_AGENTS = 8,
  parameter int N_TAGS   = 4,
  localparam int LINE_W  = ADDR_W - OFF_W,
  localparam int AGENT_W = $clog2(N_AGENTS),
  localparam int TAG_W   = $clog2(N_TAGS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic                  req_write,
  input  logic                  req_noalloc,
  input  logic [ADDR_W-1:0]     req_addr,
  input  logic [LEN_W-1:0]      req_len_m1,
  output logic [N_AGENTS-1:0]   cmd_valid,
  output logic [2:0]            cmd_op,
  output logic [LINE_W-1:0]     cmd_line,
  output logic [LINE_BYTES-1:0] cmd_be,
  output logic [TAG_W-1:0]      cmd_tag,
  input  logic                  gnt_valid,
  input  logic [TAG_W-1:0]      gnt_tag
);
  localparam logic [OFF_W-1:0] TOP = OFF_W'(LINE_BYTES - 1);

  // splitter state
  logic              busy_q, busy_d, first_q, first_d, wr_q, wr_d, na_q, na_d;
  logic [LINE_W-1:0] cur_q, cur_d, end_q, end_d;
  logic [OFF_W-1:0]  soff_q, soff_d, eoff_q, eoff_d;

  // output registers
  logic [N_AGENTS-1:0]   cv_q, cv_d;
  logic [2:0]            op_q, op_d;
  logic [LINE_W-1:0]     ln_q, ln_d;
  logic [LINE_BYTES-1:0] be_q, be_d;
  logic [TAG_W-1:0]      tg_q, tg_d;
  logic                  issue;

  logic                  last_piece, do_wb, do_piece, accept;
  logic [ADDR_W-1:0]     end_addr;
  logic [OFF_W-1:0]      piece_lo, piece_hi;
  logic [LINE_BYTES-1:0] piece_be;
  logic                  piece_full;
  logic [AGENT_W-1:0]    cur_agent, sel_agent;

  logic                  free_any, rdy_any, ent_na;
  logic [TAG_W-1:0]      free_idx, rdy_idx;
  logic [LINE_W-1:0]     ent_line;
  logic [LINE_BYTES-1:0] ent_be;
  logic [AGENT_W-1:0]    ent_agent;

  assign last_piece = (cur_q == end_q);
  assign piece_lo   = first_q ? soff_q : '0;
  assign piece_hi   = last_piece ? eoff_q : TOP;
  assign end_addr   = req_addr + ADDR_W'(req_len_m1);
  assign accept     = req_valid && !busy_q;
  assign req_ready  = !busy_q;

  ls_line_hash #(.LINE_W(LINE_W), .AGENT_W(AGENT_W)) u_hash (
    .line(cur_q), .agent(cur_agent)
  );

  ls_piece_mask u_mask (
    .lo(piece_lo), .hi(piece_hi), .be(piece_be), .full(piece_full)
  );

  ls_tag_table #(.N_TAGS(N_TAGS), .LINE_W(LINE_W), .AGENT_W(AGENT_W)) u_tags (
    .clk(clk), .rst_n(rst_n),
    .alloc_en(do_piece && wr_q), .alloc_line(cur_q), .alloc_be(piece_be),
    .alloc_agent(cur_agent), .alloc_na(na_q),
    .gnt_valid(gnt_valid), .gnt_tag(gnt_tag),
    .retire_en(do_wb),
    .free_any(free_any), .free_idx(free_idx),
    .rdy_any(rdy_any), .rdy_idx(rdy_idx),
    .ent_line(ent_line), .ent_be(ent_be), .ent_agent(ent_agent), .ent_na(ent_na)
  );

  // arbitration: granted writeback beats a new piece
  assign do_wb    = rdy_any;
  assign do_piece = busy_q && !do_wb && (!wr_q || free_any);
  assign issue    = do_wb || do_piece;

  always_comb begin
    sel_agent = do_wb ? ent_agent : cur_agent;
    cv_d      = issue ? (N_AGENTS'(1) << sel_agent) : '0;
    op_d      = 3'(OP_RD_CUR);
    ln_d      = cur_q;
    be_d      = {LINE_BYTES{1'b1}};
    tg_d      = '0;
    if (do_wb) begin
      op_d = ent_na ? 3'(OP_WB_FLUSH) : 3'(OP_WB_DATA);
      ln_d = ent_line;
      be_d = ent_be;
      tg_d = rdy_idx;
    end else if (wr_q) begin
      op_d = piece_full ? 3'(OP_OWN_FULL) : 3'(OP_OWN_PART);
      be_d = piece_be;
      tg_d = free_idx;
    end
  end

  always_comb begin
    busy_d  = busy_q;
    cur_d   = cur_q;
    end_d   = end_q;
    first_d = first_q;
    soff_d  = soff_q;
    eoff_d  = eoff_q;
    wr_d    = wr_q;
    na_d    = na_q;
    if (do_piece) begin
      if (last_piece) begin
        busy_d = 1'b0;
      end else begin
        cur_d   = cur_q + 1'b1;
        first_d = 1'b0;
      end
    end
    if (accept) begin
      busy_d  = 1'b1;
      cur_d   = req_addr[ADDR_W-1:OFF_W];
      end_d   = end_addr[ADDR_W-1:OFF_W];
      soff_d  = req_addr[OFF_W-1:0];
      eoff_d  = end_addr[OFF_W-1:0];
      first_d = 1'b1;
      wr_d    = req_write;
      na_d    = req_noalloc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      cur_q   <= '0;
      end_q   <= '0;
      first_q <= 1'b0;
      soff_q  <= '0;
      eoff_q  <= '0;
      wr_q    <= 1'b0;
      na_q    <= 1'b0;
    end else begin
      busy_q <= busy_d;
      if (accept || do_piece) begin
        cur_q   <= cur_d;
        end_q   <= end_d;
        first_q <= first_d;
        soff_q  <= soff_d;
        eoff_q  <= eoff_d;
        wr_q    <= wr_d;
        na_q    <= na_d;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cv_q <= '0;
      op_q <= '0;
      ln_q <= '0;
      be_q <= '0;
      tg_q <= '0;
    end else begin
      cv_q <= cv_d;
      if (issue) begin
        op_q <= op_d;
        ln_q <= ln_d;
        be_q <= be_d;
        tg_q <= tg_d;
      end
    end
  end

  assign cmd_valid = cv_q;
  assign cmd_op    = op_q;
  assign cmd_line  = ln_q;
  assign cmd_be    = be_q;
  assign cmd_tag   = tg_q;
endmodule

// File: rtl/ls_checker.sv
module ls_checker #(
  parameter int N_AGENTS = 8,
  parameter int LINE_W   = 34,
  parameter int TAG_W    = 2,
  localparam int AGENT_W = $clog2(N_AGENTS)
) (
  input logic                clk,
  input logic                rst_n,
  input logic                req_valid,
  input logic                req_ready,
  input logic [N_AGENTS-1:0] cmd_valid,
  input logic [2:0]          cmd_op,
  input logic [LINE_W-1:0]   cmd_line,
  input logic [63:0]         cmd_be,
  input logic [TAG_W-1:0]    cmd_tag
);
  logic [AGENT_W-1:0] fold;
  always_comb begin
    fold = '0;
    for (int b = 0; b < LINE_W; b++) fold[b % AGENT_W] = fold[b % AGENT_W] ^ cmd_line[b];
  end

  AST_VALID_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cmd_valid)); // R6
  AST_HASH_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    (|cmd_valid) |-> (cmd_valid == (N_AGENTS'(1) << fold))); // R6
  AST_OP_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (|cmd_valid) |-> (cmd_op >= 3'd1 && cmd_op <= 3'd5)); // R4
  AST_READ_WHOLE: assert property (@(posedge clk) disable iff (!rst_n)
    ((|cmd_valid) && cmd_op == 3'd1) |-> (&cmd_be && cmd_tag == '0)); // R5
  AST_OWN_FULL_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    ((|cmd_valid) && cmd_op == 3'd2) |-> (&cmd_be)); // R4
  AST_OWN_PART_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    ((|cmd_valid) && cmd_op == 3'd3) |-> (!(&cmd_be) && (|cmd_be))); // R3
  AST_READY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready); // R11
endmodule

bind line_splitter ls_checker #(
  .N_AGENTS(N_AGENTS), .LINE_W(LINE_W), .TAG_W(TAG_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_line(cmd_line),
  .cmd_be(cmd_be), .cmd_tag(cmd_tag)
);

// File: tb/line_splitter_tb.sv
module line_splitter_tb;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W   = 40;
  localparam int LEN_W    = 12;
  localparam int N_AGENTS = 8;
  localparam int N_TAGS   = 4;
  localparam int LINE_W   = ADDR_W - 6;
  localparam int AGENT_W  = $clog2(N_AGENTS);
  localparam int TAG_W    = $clog2(N_TAGS);

  logic clk, rst_n;
  logic req_valid, req_ready, req_write, req_noalloc;
  logic [ADDR_W-1:0] req_addr;
  logic [LEN_W-1:0]  req_len_m1;
  logic [N_AGENTS-1:0] cmd_valid;
  logic [2:0] cmd_op;
  logic [LINE_W-1:0] cmd_line;
  logic [63:0] cmd_be;
  logic [TAG_W-1:0] cmd_tag;
  logic gnt_valid;
  logic [TAG_W-1:0] gnt_tag;

  line_splitter #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .N_AGENTS(N_AGENTS), .N_TAGS(N_TAGS)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_noalloc(req_noalloc), .req_addr(req_addr),
    .req_len_m1(req_len_m1), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_line(cmd_line), .cmd_be(cmd_be), .cmd_tag(cmd_tag),
    .gnt_valid(gnt_valid), .gnt_tag(gnt_tag)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 0;

  task automatic chk(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int hsh(logic [LINE_W-1:0] l);
    int h = 0;
    for (int b = 0; b < LINE_W; b++) h = h ^ (int'(l[b]) << (b % AGENT_W));
    return h;
  endfunction

  // ---------------- behavioural reference model ----------------
  bit m_busy, m_first, m_wr, m_na;
  logic [LINE_W-1:0] m_cur, m_end;
  int m_soff, m_eoff;
  bit m_tv [N_TAGS];
  bit m_tg [N_TAGS];
  logic [LINE_W-1:0] m_tl [N_TAGS];
  logic [63:0] m_tb [N_TAGS];
  bit m_tna [N_TAGS];
  bit e_valid;
  int e_op, e_tag;
  logic [LINE_W-1:0] e_line;
  logic [63:0] e_be;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0;
      e_valid = 0;
      for (int t = 0; t < N_TAGS; t++) begin m_tv[t] = 0; m_tg[t] = 0; end
    end else begin
      bit gok, old_busy;
      int g, f, lo, hi;
      logic [ADDR_W-1:0] ea;
      gok = gnt_valid && m_tv[gnt_tag] && !m_tg[gnt_tag];
      old_busy = m_busy;
      g = -1; f = -1;
      for (int t = N_TAGS - 1; t >= 0; t--) begin
        if (m_tg[t]) g = t;
        if (!m_tv[t]) f = t;
      end
      e_valid = 0;
      if (g >= 0) begin
        e_valid = 1; e_op = m_tna[g] ? 5 : 4; e_line = m_tl[g]; e_be = m_tb[g]; e_tag = g;
        m_tv[g] = 0; m_tg[g] = 0;
      end else if (m_busy && (!m_wr || f >= 0)) begin
        lo = m_first ? m_soff : 0;
        hi = (m_cur == m_end) ? m_eoff : 63;
        e_valid = 1; e_line = m_cur;
        if (m_wr) begin
          e_be = '0;
          for (int b = lo; b <= hi; b++) e_be[b] = 1'b1;
          e_op = (lo == 0 && hi == 63) ? 2 : 3; e_tag = f;
          m_tv[f] = 1; m_tl[f] = m_cur; m_tb[f] = e_be; m_tna[f] = m_na;
        end else begin
          e_op = 1; e_be = '1; e_tag = 0;
        end
        if (m_cur == m_end) m_busy = 0;
        else begin m_cur = m_cur + 1; m_first = 0; end
      end
      if (!old_busy && req_valid) begin
        ea = req_addr + ADDR_W'(req_len_m1);
        m_busy = 1; m_first = 1; m_wr = req_write; m_na = req_noalloc;
        m_cur = req_addr[ADDR_W-1:6]; m_end = ea[ADDR_W-1:6];
        m_soff = int'(req_addr[5:0]); m_eoff = int'(ea[5:0]);
      end
      if (gok) m_tg[gnt_tag] = 1;
    end
  end

  // ---------------- compare, observe and grant driver ----------------
  int gmode = 0, hold = 0;
  int pq [$];
  int c_rd, c_own, c_wb, c_fl;

  initial begin
    gnt_valid = 0; gnt_tag = '0;
    forever begin
      @(negedge clk);
      if (!rst_n) begin
        gnt_valid = 0;
      end else begin
        logic [N_AGENTS-1:0] ev;
        ev = e_valid ? (N_AGENTS'(1) << hsh(e_line)) : '0;
        chk(req_ready == !m_busy, "R11 ready", req_ready, !m_busy);
        chk(cmd_valid == ev, "R6 valid/agent", cmd_valid, ev);
        if (e_valid && |cmd_valid) begin
          chk(cmd_op == 3'(e_op), "R4 opcode", cmd_op, e_op);
          chk(cmd_line == e_line, "R2 line", cmd_line, e_line);
          chk(cmd_be == e_be, "R3 byte enable", cmd_be, e_be);
          chk(cmd_tag == TAG_W'(e_tag), "R9 tag", cmd_tag, e_tag);
        end
        if (|cmd_valid) begin
          case (cmd_op)
            3'd1: c_rd++;
            3'd2, 3'd3: begin c_own++; pq.push_back(int'(cmd_tag)); end
            3'd4: c_wb++;
            3'd5: c_fl++;
            default: ;
          endcase
        end
        gnt_valid = 0;
        hold++;
        case (gmode)
          0: if (pq.size() > 0) begin gnt_tag = TAG_W'(pq.pop_front()); gnt_valid = 1; end
          1: if (pq.size() > 0 && (pq.size() >= N_TAGS || hold > 6)) begin
               gnt_tag = TAG_W'(pq.pop_back()); gnt_valid = 1; hold = 0;
             end
          default: begin
            if (hold % 3 == 0 && pq.size() > 0) begin
              gnt_tag = TAG_W'(pq.pop_front()); gnt_valid = 1;
            end else if (hold % 3 == 1) begin
              // grant a tag that is not waiting: must be ignored (R9)
              for (int t = 0; t < N_TAGS; t++) begin
                bit inq = 0;
                foreach (pq[i]) if (pq[i] == t) inq = 1;
                if (!inq && !gnt_valid) begin gnt_tag = TAG_W'(t); gnt_valid = 1; end
              end
            end
          end
        endcase
      end
    end
  end

  // ---------------- stimulus ----------------
  task automatic send(bit wr, bit na, logic [ADDR_W-1:0] a, int lm1);
    @(negedge clk);
    req_valid = 1; req_write = wr; req_noalloc = na; req_addr = a; req_len_m1 = LEN_W'(lm1);
    forever begin
      if (req_ready) begin @(posedge clk); break; end
      @(negedge clk);
    end
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic drain();
    @(negedge clk);
    while (!(req_ready && pq.size() == 0)) @(negedge clk);
    repeat (12) @(negedge clk);
  endtask

  function automatic int nlines(logic [ADDR_W-1:0] a, int lm1);
    return (int'(a[5:0]) + lm1) / 64 + 1;
  endfunction

  task automatic run(bit wr, bit na, logic [ADDR_W-1:0] a, int lm1, int mode);
    int n;
    gmode = mode; c_rd = 0; c_own = 0; c_wb = 0; c_fl = 0;
    send(wr, na, a, lm1);
    drain();
    n = nlines(a, lm1);
    if (!wr) chk(c_rd == n, "R5 read count", c_rd, n);
    else begin
      chk(c_own == n, "R2 piece count", c_own, n);
      if (na) chk(c_fl == n && c_wb == 0, "R8 flush count", c_fl, n);
      else    chk(c_wb == n && c_fl == 0, "R7 writeback count", c_wb, n);
    end
  endtask

  initial begin
    logic [31:0] lf;
    int tot_l, tot_w, tot_r;
    rst_n = 0; req_valid = 0; req_write = 0; req_noalloc = 0; req_addr = '0; req_len_m1 = '0;
    repeat (3) @(negedge clk);
    chk(cmd_valid == '0, "R1 valid in reset", cmd_valid, 0);
    chk(req_ready == 1'b1, "R1 ready in reset", req_ready, 1);
    rst_n = 1;
    @(negedge clk);
    chk(cmd_valid == '0, "R1 valid after reset", cmd_valid, 0);
    chk(req_ready == 1'b1, "R1 ready after reset", req_ready, 1);

    run(0, 0, 40'h00_0000_1000, 63, 0);        // R5 aligned full read
    run(0, 0, 40'h00_1234_500A, 149, 0);       // R5 partial read over three lines
    run(1, 0, 40'h00_0000_2000, 255, 0);       // R4 full-line ownership
    run(1, 0, 40'h00_ABCD_0021, 199, 1);       // R3 partial edges, R7 reverse grants
    run(1, 1, 40'h0F_0000_0010, 129, 0);       // R8 non-allocating
    run(1, 0, 40'h00_5555_4000, 1023, 1);      // R9 tag exhaustion, R10 priority
    run(1, 0, 40'h00_5555_8008, 511, 2);       // R9 stray grants ignored
    run(1, 0, 40'h00_0000_303F, 0, 0);         // R3 single byte at offset 63
    run(1, 0, 40'h00_0000_3040, 63, 2);        // R4 exact line

    // back-to-back mix, drained once (R10, R11)
    lf = 32'h1ACE_B00C; tot_l = 0; tot_w = 0; tot_r = 0;
    c_rd = 0; c_own = 0; c_wb = 0; c_fl = 0;
    for (int k = 0; k < 24; k++) begin
      logic [ADDR_W-1:0] a;
      int lm1;
      bit wr;
      lf = lf ^ (lf << 13); lf = lf ^ (lf >> 17); lf = lf ^ (lf << 5);
      a = {8'(k), lf};
      lm1 = int'(lf[24:16]);
      wr = lf[3];
      gmode = k % 3;
      if (wr) tot_w += nlines(a, lm1); else tot_r += nlines(a, lm1);
      send(wr, 1'b0, a, lm1);
    end
    drain();
    chk(c_rd == tot_r, "R2 mixed read pieces", c_rd, tot_r);
    chk(c_own == tot_w, "R2 mixed write pieces", c_own, tot_w);
    chk(c_wb == tot_w, "R7 mixed writebacks", c_wb, tot_w);

    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule